// File: doc/BRIEF.md
# Four-Input ADC Scan Sequencer

This block is an SPI master for an external 24-bit delta-sigma converter. It reads four single-ended inputs in turn, using one-shot commands instead of the converter's continuous-read mode. After a start pulse it first halts any continuous output from the converter. It then writes the status, control and data-rate registers and runs a self-calibration. Each stage waits for a data-ready falling edge or for a fixed pause, as the converter's timing needs.

Once setup is done, the block repeats one loop per sample. On a data-ready falling edge it writes the input-select register with the next channel. It pauses, then sends sync, wake-up and read-data as one chip-select group. After a longer pause it clocks in 24 result bits. Each conversion finishes before the new selection takes effect, so every result belongs to the channel selected in the previous loop. The block therefore tags each result one channel behind the selection it has just made. The first result after start has no real predecessor, so it is flagged.

Top module: `adc_mux_scan`

## Requirements
- R1: After reset and before `start`, `cs_n` is high, `sclk` is low, `mosi` is low and `sample_valid` is low, even while `drdy_n` toggles.
- R2: SCLK idles low. Each bit is sent MSB first: `mosi` changes when `sclk` rises, and `miso` is sampled when `sclk` falls. `sclk` stays high for exactly `HALF_DIV` clock cycles per bit.
- R3: After `start`, the block sends these bytes in order:
  - on the first data-ready fall: 0x0F;
  - on the next fall: 0x50 0x00 0x00 (status), then 0x52 0x00 0x00 (control), then 0x53 0x00 `RATE_CODE` (rate, default 0xC0);
  - on the following fall: 0xF0 (self-calibration).
- R4: Each sample loop starts on a data-ready fall. It writes 0x51 0x00 code, where code is 0x80 plus the channel number. Channels run 0, 1, 2, 3 and then wrap to 0.
- R5: After the input-select write and its pause, the block sends 0xFC 0x00 0x01. It then clocks 24 bits with `mosi` held low.
- R6: `cs_n` is low whenever `sclk` is high. It goes high after the 0x0F byte, after each register write, after 0xF0 and after each data read. It stays low from 0xFC until the end of the data read.
- R7: After each read, `sample_valid` pulses for one cycle. `sample_data` carries the 24 received bits, MSB first. `sample_chan` is the channel selected one loop earlier, so it is 3 for the loop that selected channel 0.
- R8: `sample_first` is 1 on the first result after `start` and 0 on every later result.
- R9: A `start` pulse while the scan is running has no effect on the byte stream or on the tags.
- R10: SCLK stays low for at least `WAIT_SHORT` cycles after each register write and after the 0xF0 byte. It stays low for at least `WAIT_LONG` cycles between the 0x01 byte and the first data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins setup and scanning; ignored once running |
| drdy_n | input | 1 | Data-ready from the converter, active low |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Chip select, active low |
| sample_valid | output | 1 | One-cycle result strobe |
| sample_data | output | 24 | Conversion result |
| sample_chan | output | 2 | Channel the result belongs to |
| sample_first | output | 1 | Marks the first result, whose tag is not meaningful |

## Verification
The bench builds the block with `HALF_DIV` = 2, `WAIT_SHORT` = 20 and `WAIT_LONG` = 30. With these values one sample loop fits inside a 500-cycle data-ready period. Ten samples therefore cover more than two full wraps of the channel order, and the pause lengths can be measured edge by edge. The converter model returns all-ones and near-zero words among the results, so bit order and MSB handling are exercised.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [2:0] {
    OP_DRDY,   // wait for a data-ready falling edge
    OP_BYTE,   // shift one command byte
    OP_SHORT,  // short settle pause
    OP_LONG,   // pause before data read
    OP_READ    // clock in the result word
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] data;
    logic       fin;   // this byte closes a chip-select group
  } step_t;

  localparam logic [7:0] OPC_HALT_CONT = 8'h0F;
  localparam logic [7:0] OPC_CAL_SELF  = 8'hF0;
  localparam logic [7:0] OPC_SYNC      = 8'hFC;
  localparam logic [7:0] OPC_WAKE      = 8'h00;
  localparam logic [7:0] OPC_READ_ONE  = 8'h01;
  localparam logic [3:0] OPC_WRITE_REG = 4'h5;

  localparam logic [3:0] REG_STAT = 4'd0;
  localparam logic [3:0] REG_SEL  = 4'd1;
  localparam logic [3:0] REG_CTRL = 4'd2;
  localparam logic [3:0] REG_RATE = 4'd3;

  localparam logic [4:0] STEP_LOOP = 5'd18;
  localparam logic [4:0] STEP_LAST = 5'd27;

  function automatic step_t mk(input op_e op, input logic [7:0] d, input logic f);
    step_t s;
    s.op   = op;
    s.data = d;
    s.fin  = f;
    return s;
  endfunction

  function automatic logic [7:0] wr_head(input logic [3:0] reg_addr);
    return {OPC_WRITE_REG, reg_addr};
  endfunction

  function automatic logic [7:0] sel_code(input logic [7:0] chan);
    return 8'h80 | chan;
  endfunction

  // Micro-program: setup steps 0..17, per-sample loop 18..27
  function automatic step_t scan_step(input logic [4:0] idx, input logic [7:0] chan,
                                      input logic [7:0] rate);
    case (idx)
      5'd0:  return mk(OP_DRDY, 8'h00, 1'b0);
      5'd1:  return mk(OP_BYTE, OPC_HALT_CONT, 1'b1);
      5'd2:  return mk(OP_DRDY, 8'h00, 1'b0);
      5'd3:  return mk(OP_BYTE, wr_head(REG_STAT), 1'b0);
      5'd4:  return mk(OP_BYTE, 8'h00, 1'b0);
      5'd5:  return mk(OP_BYTE, 8'h00, 1'b1);
      5'd6:  return mk(OP_SHORT, 8'h00, 1'b0);
      5'd7:  return mk(OP_BYTE, wr_head(REG_CTRL), 1'b0);
      5'd8:  return mk(OP_BYTE, 8'h00, 1'b0);
      5'd9:  return mk(OP_BYTE, 8'h00, 1'b1);
      5'd10: return mk(OP_SHORT, 8'h00, 1'b0);
      5'd11: return mk(OP_BYTE, wr_head(REG_RATE), 1'b0);
      5'd12: return mk(OP_BYTE, 8'h00, 1'b0);
      5'd13: return mk(OP_BYTE, rate, 1'b1);
      5'd14: return mk(OP_SHORT, 8'h00, 1'b0);
      5'd15: return mk(OP_DRDY, 8'h00, 1'b0);
      5'd16: return mk(OP_BYTE, OPC_CAL_SELF, 1'b1);
      5'd17: return mk(OP_SHORT, 8'h00, 1'b0);
      5'd18: return mk(OP_DRDY, 8'h00, 1'b0);
      5'd19: return mk(OP_BYTE, wr_head(REG_SEL), 1'b0);
      5'd20: return mk(OP_BYTE, 8'h00, 1'b0);
      5'd21: return mk(OP_BYTE, sel_code(chan), 1'b1);
      5'd22: return mk(OP_SHORT, 8'h00, 1'b0);
      5'd23: return mk(OP_BYTE, OPC_SYNC, 1'b0);
      5'd24: return mk(OP_BYTE, OPC_WAKE, 1'b0);
      5'd25: return mk(OP_BYTE, OPC_READ_ONE, 1'b0);
      5'd26: return mk(OP_LONG, 8'h00, 1'b0);
      default: return mk(OP_READ, 8'h00, 1'b1);
    endcase
  endfunction

endpackage

// File: rtl/scan_edge_sync.sv
module scan_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  output logic fall
);
  logic meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      cur_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= din_n;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign fall = prev_q & ~cur_q;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R4

endmodule

// File: rtl/scan_wait_timer.sv
module scan_wait_timer #(
  parameter int WAIT_SHORT = 250,
  parameter int WAIT_LONG  = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic use_long,
  output logic expired
);
  localparam int MAXW = (WAIT_LONG > WAIT_SHORT) ? WAIT_LONG : WAIT_SHORT;
  localparam int TW   = $clog2(MAXW + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= use_long ? TW'(WAIT_LONG) : TW'(WAIT_SHORT);
    else if (cnt_q != '0)  cnt_q <= cnt_q - TW'(1);
  end

  assign expired = (cnt_q == '0);

  AST_TIMER_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/scan_spi_shifter.sv
module scan_spi_shifter #(
  parameter int HALF_DIV = 13,
  parameter int WORD     = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            long_word,
  input  logic [7:0]      tx_byte,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic [WORD-1:0] rx_word,
  output logic            busy,
  output logic            done
);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam int BW = $clog2(WORD + 1);

  logic [DW-1:0]   div_q;
  logic [BW-1:0]   left_q;
  logic [WORD-1:0] tx_q, rx_q;
  logic            sclk_q, busy_q, done_q;
  logic            half_end;

  assign half_end = (div_q == DW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      left_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go) begin
          busy_q <= 1'b1;
          sclk_q <= 1'b1;
          div_q  <= '0;
          left_q <= long_word ? BW'(WORD) : BW'(8);
          tx_q   <= long_word ? '0 : {tx_byte, {(WORD-8){1'b0}}};
        end
      end else if (half_end) begin
        div_q <= '0;
        if (sclk_q) begin
          sclk_q <= 1'b0;
          rx_q   <= {rx_q[WORD-2:0], miso};
        end else if (left_q == BW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          left_q <= left_q - BW'(1);
          tx_q   <= {tx_q[WORD-2:0], 1'b0};
          sclk_q <= 1'b1;
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = busy_q & tx_q[WORD-1];
  assign rx_word = rx_q;
  assign busy    = busy_q;
  assign done    = done_q;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q); // R2

endmodule

// File: rtl/adc_mux_scan.sv
module adc_mux_scan
  import adc_scan_pkg::*;
#(
  parameter int         HALF_DIV   = 13,
  parameter int         WAIT_SHORT = 250,
  parameter int         WAIT_LONG  = 400,
  parameter logic [7:0] RATE_CODE  = 8'hC0,
  parameter int         NUM_CH     = 4,
  parameter int         DATA_BITS  = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 drdy_n,
  input  logic                 miso,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 cs_n,
  output logic                 sample_valid,
  output logic [DATA_BITS-1:0] sample_data,
  output logic [1:0]           sample_chan,
  output logic                 sample_first
);
  localparam int CH_W = 2;

  function automatic logic [CH_W-1:0] chan_after(input logic [CH_W-1:0] c);
    return (c == CH_W'(NUM_CH - 1)) ? '0 : c + CH_W'(1);
  endfunction

  function automatic logic [CH_W-1:0] chan_before(input logic [CH_W-1:0] c);
    return (c == '0) ? CH_W'(NUM_CH - 1) : c - CH_W'(1);
  endfunction

  // Internal events brought out for checking
  logic                 running_q, phase_q, cs_q, first_pend_q;
  logic [4:0]           step_q;
  logic [CH_W-1:0]      sel_q;
  step_t                cur;
  logic                 eng_go, eng_busy, eng_done;
  logic                 tmr_load, tmr_long, tmr_exp;
  logic                 drdy_fall;
  logic [DATA_BITS-1:0] eng_rx;
  logic                 valid_q, first_q;
  logic [DATA_BITS-1:0] data_q;
  logic [CH_W-1:0]      tag_q;

  assign cur      = scan_step(step_q, 8'(sel_q), RATE_CODE);
  assign eng_go   = running_q && !phase_q && (cur.op == OP_BYTE || cur.op == OP_READ);
  assign tmr_load = running_q && !phase_q && (cur.op == OP_SHORT || cur.op == OP_LONG);
  assign tmr_long = (cur.op == OP_LONG);

  scan_edge_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din_n (drdy_n),
    .fall  (drdy_fall)
  );

  scan_wait_timer #(.WAIT_SHORT(WAIT_SHORT), .WAIT_LONG(WAIT_LONG)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .use_long (tmr_long),
    .expired  (tmr_exp)
  );

  scan_spi_shifter #(.HALF_DIV(HALF_DIV), .WORD(DATA_BITS)) u_spi (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (eng_go),
    .long_word (cur.op == OP_READ),
    .tx_byte   (cur.data),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .rx_word   (eng_rx),
    .busy      (eng_busy),
    .done      (eng_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q    <= 1'b0;
      phase_q      <= 1'b0;
      cs_q         <= 1'b1;
      first_pend_q <= 1'b0;
      step_q       <= '0;
      sel_q        <= '0;
      valid_q      <= 1'b0;
      first_q      <= 1'b0;
      data_q       <= '0;
      tag_q        <= '0;
    end else begin
      valid_q <= 1'b0;
      if (!running_q) begin
        if (start) begin
          running_q    <= 1'b1;
          step_q       <= '0;
          phase_q      <= 1'b0;
          sel_q        <= '0;
          first_pend_q <= 1'b1;
        end
      end else begin
        case (cur.op)
          OP_DRDY: if (drdy_fall) step_q <= step_q + 5'd1;
          OP_SHORT, OP_LONG: begin
            if (!phase_q) phase_q <= 1'b1;
            else if (tmr_exp) begin
              phase_q <= 1'b0;
              step_q  <= step_q + 5'd1;
            end
          end
          OP_BYTE: begin
            if (!phase_q) begin
              phase_q <= 1'b1;
              cs_q    <= 1'b0;
            end else if (eng_done) begin
              phase_q <= 1'b0;
              step_q  <= step_q + 5'd1;
              if (cur.fin) cs_q <= 1'b1;
            end
          end
          default: begin
            if (!phase_q) begin
              phase_q <= 1'b1;
              cs_q    <= 1'b0;
            end else if (eng_done) begin
              phase_q      <= 1'b0;
              cs_q         <= 1'b1;
              step_q       <= STEP_LOOP;
              valid_q      <= 1'b1;
              data_q       <= eng_rx;
              tag_q        <= chan_before(sel_q);
              first_q      <= first_pend_q;
              first_pend_q <= 1'b0;
              sel_q        <= chan_after(sel_q);
            end
          end
        endcase
      end
    end
  end

  assign cs_n         = cs_q;
  assign sample_valid = valid_q;
  assign sample_data  = data_q;
  assign sample_chan  = tag_q;
  assign sample_first = first_q;

  AST_CS_WHEN_CLOCKING: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n); // R6

  AST_DIN_LOW_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.op == OP_READ && eng_busy) |-> !mosi); // R5

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid); // R7

  AST_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && start && step_q != '0) |=> (step_q != '0)); // R9

  AST_FIRST_ONLY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !first_pend_q && $past(!first_pend_q)) |-> !sample_first); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> (cs_n && !sclk && !sample_valid)); // R1

endmodule

// File: tb/adc_mux_scan_test.sv
module adc_mux_scan_test;
  localparam int HALF  = 2;
  localparam int WS    = 20;
  localparam int WL    = 30;
  localparam int N_SMP = 10;
  localparam int DRDY_PER = 500;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, drdy_n = 1'b1, miso = 1'b0;
  logic sclk, mosi, cs_n, sample_valid, sample_first;
  logic [23:0] sample_data;
  logic [1:0]  sample_chan;

  int n_chk = 0, n_fail = 0, samples_seen = 0;
  bit wd_fired = 1'b0;

  always #10 clk = ~clk;

  adc_mux_scan #(.HALF_DIV(HALF), .WAIT_SHORT(WS), .WAIT_LONG(WL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .drdy_n(drdy_n), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .sample_valid(sample_valid),
    .sample_data(sample_data), .sample_chan(sample_chan), .sample_first(sample_first)
  );

  typedef struct {
    logic [7:0] val;
    int         gap;
    bit         grp_end;
    int         kind;   // 0 plain, 1 select code, 2 read command, 3 data bits
    string      req;
  } exp_byte_t;

  typedef struct {
    logic [23:0] data;
    logic [1:0]  chan;
    bit          first;
  } exp_smp_t;

  exp_byte_t byte_q[$];
  exp_smp_t  smp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push_b(input logic [7:0] v, input int gap, input bit e,
                        input int kind, input string req);
    exp_byte_t b;
    b.val = v; b.gap = gap; b.grp_end = e; b.kind = kind; b.req = req;
    byte_q.push_back(b);
  endtask

  // Driver: expected command stream
  task automatic push_setup();
    push_b(8'h0F, 0, 1, 0, "R3");
    push_b(8'h50, 0, 0, 0, "R3"); push_b(8'h00, 0, 0, 0, "R3"); push_b(8'h00, WS, 1, 0, "R3");
    push_b(8'h52, 0, 0, 0, "R3"); push_b(8'h00, 0, 0, 0, "R3"); push_b(8'h00, WS, 1, 0, "R3");
    push_b(8'h53, 0, 0, 0, "R3"); push_b(8'h00, 0, 0, 0, "R3"); push_b(8'hC0, WS, 1, 0, "R3");
    push_b(8'hF0, WS, 1, 0, "R3");
  endtask

  task automatic push_sample(input int n);
    string r;
    r = (n >= 4) ? "R9" : "R4";
    push_b(8'h51, 0, 0, 0, r);
    push_b(8'h00, 0, 0, 0, r);
    push_b(8'h80 | 8'(n % 4), WS, 1, 1, r);
    push_b(8'hFC, 0, 0, 0, "R5");
    push_b(8'h00, 0, 0, 0, "R5");
    push_b(8'h01, WL, 0, 2, "R5");
    push_b(8'h00, 0, 0, 3, "R5");
    push_b(8'h00, 0, 0, 3, "R5");
    push_b(8'h00, 0, 1, 3, "R5");
  endtask

  // Converter data-ready pulses
  initial begin
    @(posedge rst_n);
    forever begin
      drdy_n = 1'b1;
      repeat (4) @(negedge clk);
      drdy_n = 1'b0;
      repeat (DRDY_PER - 4) @(negedge clk);
    end
  end

  // Monitor: converter model plus scoreboard
  initial begin
    logic prev_sclk = 1'b0, prev_cs = 1'b1;
    bit   cs_rose = 1'b0, have_sel = 1'b0, have_prev = 1'b0;
    int   hi_len = 0, lo_len = 0, bit_cnt = 0, rd_left = 0, pend_gap = 0, rd_no = 0;
    bit   pend_end = 1'b0;
    logic [7:0]  cur_byte = '0;
    logic [1:0]  cur_sel = '0, prev_sel = '0;
    logic [23:0] sh = '0;
    forever begin
      @(negedge clk);
      if (samples_seen < N_SMP && rst_n) begin
        if (cs_n && !prev_cs) cs_rose = 1'b1;
        if (sclk && !prev_sclk) begin
          if (bit_cnt == 0) begin
            if (pend_gap > 0)
              chk(lo_len >= pend_gap, "R10", "sclk low gap", lo_len, pend_gap);
            chk(cs_rose == pend_end, "R6", "cs release between groups", cs_rose, pend_end);
            cs_rose = 1'b0;
          end
          hi_len = 0;
        end
        if (!sclk && prev_sclk) begin
          if (bit_cnt == 0) chk(hi_len == HALF, "R2", "sclk high time", hi_len, HALF);
          cur_byte = {cur_byte[6:0], mosi};
          bit_cnt++;
          lo_len = 0;
          if (rd_left > 0) begin
            sh = {sh[22:0], 1'b0};
            miso = sh[23];
            rd_left--;
          end
          if (bit_cnt == 8) begin
            bit_cnt = 0;
            if (byte_q.size() == 0) begin
              chk(1'b0, "R3", "unexpected byte", cur_byte, 0);
            end else begin
              exp_byte_t e;
              e = byte_q.pop_front();
              chk(cur_byte == e.val, e.req, "mosi byte", cur_byte, e.val);
              pend_gap = e.gap;
              pend_end = e.grp_end;
              if (e.kind == 1) begin
                prev_sel = cur_sel; have_prev = have_sel;
                cur_sel = e.val[1:0]; have_sel = 1'b1;
              end
              if (e.kind == 2) begin
                exp_smp_t s;
                s.chan  = have_prev ? prev_sel : 2'd3;
                s.first = !have_prev;
                if (rd_no == 2)      s.data = 24'hFFFFFF;
                else if (rd_no == 4) s.data = 24'h000001;
                else s.data = 24'(32'h00A5_0000 + rd_no * 32'h0001_0307) ^ {s.chan, 22'd0};
                smp_q.push_back(s);
                sh = s.data;
                miso = sh[23];
                rd_left = 24;
                rd_no++;
              end
            end
          end
        end
        if (sclk) hi_len++; else lo_len++;
        if (sample_valid) begin
          if (smp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected sample", sample_data, 0);
          end else begin
            exp_smp_t s;
            s = smp_q.pop_front();
            chk(sample_data == s.data, "R7", "sample data", sample_data, s.data);
            chk(sample_chan == s.chan, "R7", "sample tag", sample_chan, s.chan);
            chk(sample_first == s.first, "R8", "first flag", sample_first, s.first);
          end
          samples_seen++;
        end
      end
      prev_sclk = sclk;
      prev_cs   = cs_n;
    end
  end

  // Watchdog
  initial begin
    repeat (60000) @(posedge clk);
    wd_fired = 1'b1;
  end

  initial begin
    bit quiet;
    push_setup();
    for (int n = 0; n < N_SMP; n++) push_sample(n);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);
    chk(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
    chk(sample_valid == 1'b0, "R1", "valid after reset", sample_valid, 0);
    quiet = 1'b1;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (!cs_n || sclk || mosi || sample_valid) quiet = 1'b0;
    end
    chk(quiet, "R1", "no activity before start", quiet, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (samples_seen >= 3 || wd_fired);
    @(negedge clk);
    start = 1'b1;   // R9: must not restart the scan
    @(negedge clk);
    start = 1'b0;
    wait (samples_seen >= N_SMP || wd_fired);
    if (wd_fired) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual %0d samples expected %0d", samples_seen, N_SMP);
    end else begin
      chk(byte_q.size() == 0, "R4", "bytes left in queue", byte_q.size(), 0);
      chk(smp_q.size() == 0, "R7", "samples left in queue", smp_q.size(), 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule